// File: doc/BRIEF.md
# Signed-Amount Bidirectional Shift ALU

A purely combinational arithmetic and logic unit for the execute stage of a small 32-bit processor. A 4-bit operation code chooses one of twelve functions applied to two operands, `opa` and `opb`. The result appears in the same cycle the inputs change. The functions are:

- wrapping add, subtract and multiply;
- signed division that rounds toward negative infinity;
- absolute value;
- the bitwise functions;
- a pass-through;
- two shifts.

In both shifts, the sign of `opb` picks the direction. A positive amount moves bits toward the most significant end. A negative amount moves them toward the least significant end. The arithmetic shift copies the sign bit into the vacated positions, and the logical shift fills them with zeros.

Division by zero never traps. It returns a zero result and raises `div_zero` for that operation only. The unit has no flags, no register state and no clock. The surrounding pipeline registers its inputs and outputs.

Top module: `sshift_alu`

## Requirements
- R1: Codes 1 (add), 2 (subtract, opa minus opb) and 3 (multiply) return the low 32 bits of the two's-complement result.
- R2: Code 4 divides opa by opb as signed integers and rounds the quotient toward negative infinity. For example, -7 divided by 2 gives -4, and 7 divided by -2 gives -4.
- R3: When code 4 is given with opb equal to zero, result is zero and div_zero is 1. div_zero is 0 for every other code and operand combination.
- R4: Code 5 returns the absolute value of opa read as signed. For 0x80000000, it returns 0x80000000 unchanged.
- R5: Codes 6, 7 and 8 return opa AND, OR and XOR opb. Code 9 returns the bitwise complement of opa. Code 0 returns opa unchanged.
- R6: Code 10 (arithmetic shift) shifts opa left by opb when opb is zero or positive. When opb is negative, it shifts opa right by the magnitude of opb and fills with copies of bit 31.
- R7: Code 11 (logical shift) shifts opa left by opb when opb is zero or positive. When opb is negative, it shifts opa right by the magnitude of opb and fills with zeros.
- R8: A shift magnitude of 32 or more, including opb equal to 0x80000000, gives zero for left shifts and logical right shifts. For arithmetic right shifts it gives 32 copies of bit 31 of opa.
- R9: Codes 12 to 15 return zero.
- R10: Code 4 with opa equal to 0x80000000 and opb equal to 0xFFFFFFFF returns 0x80000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 4 | Operation code |
| opa | input | 32 | First operand: dividend, shifted value, source of the unary functions |
| opb | input | 32 | Second operand: divisor, signed shift amount |
| result | output | 32 | Function result |
| div_zero | output | 1 | High when code 4 is given with a zero divisor |

## Verification
Two functions can fall in the same cycle:

- **Division with saturation.** The division path's zero-divisor guard and its floor correction act in one evaluation. The bench crosses them with the signed overflow case, 0x80000000 divided by -1, which must wrap rather than saturate.
- **Shifts with saturation.** Each shift's direction choice and its saturation detection also act together. Amounts of exactly ±32 and 0x80000000 test whether the magnitude taken from a negative amount is judged correctly for both fill rules.

The bench judges a vector table of hand-computed results for all codes. It then compares floor quotients and shift results over operand sweeps against integer arithmetic written independently in the bench.

// File: rtl/sshift_alu.sv
module sshift_alu #(
  parameter int W   = 32,
  parameter int OPW = 4
) (
  input  logic [OPW-1:0] op,
  input  logic [W-1:0]   opa,
  input  logic [W-1:0]   opb,
  output logic [W-1:0]   result,
  output logic           div_zero
);
  localparam int SHW = $clog2(W);
  localparam logic [OPW-1:0] OP_PASS = OPW'(0);
  localparam logic [OPW-1:0] OP_ADD  = OPW'(1);
  localparam logic [OPW-1:0] OP_SUB  = OPW'(2);
  localparam logic [OPW-1:0] OP_MUL  = OPW'(3);
  localparam logic [OPW-1:0] OP_DIV  = OPW'(4);
  localparam logic [OPW-1:0] OP_ABS  = OPW'(5);
  localparam logic [OPW-1:0] OP_AND  = OPW'(6);
  localparam logic [OPW-1:0] OP_OR   = OPW'(7);
  localparam logic [OPW-1:0] OP_XOR  = OPW'(8);
  localparam logic [OPW-1:0] OP_NOT  = OPW'(9);
  localparam logic [OPW-1:0] OP_ASH  = OPW'(10);
  localparam logic [OPW-1:0] OP_LSH  = OPW'(11);
  localparam logic [W-1:0]   MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic         a_neg, b_neg;
  logic [W-1:0] mag_a, mag_b, div_b, uq, ur, round_adj, floor_q;

  assign a_neg     = opa[W-1];
  assign b_neg     = opb[W-1];
  assign mag_a     = a_neg ? -opa : opa;
  assign mag_b     = b_neg ? -opb : opb;
  assign div_b     = (mag_b == '0) ? {{(W-1){1'b0}}, 1'b1} : mag_b;
  assign uq        = mag_a / div_b;
  assign ur        = mag_a % div_b;
  assign round_adj = {{(W-1){1'b0}}, |ur};
  assign floor_q   = (a_neg ^ b_neg) ? (-uq - round_adj) : uq;

  logic           sh_sat;
  logic [SHW-1:0] sh_amt;
  logic [W-1:0]   sh_left, sh_rlog, sh_rari;

  assign sh_sat  = |mag_b[W-1:SHW];
  assign sh_amt  = mag_b[SHW-1:0];
  assign sh_left = sh_sat ? '0 : (opa << sh_amt);
  assign sh_rlog = sh_sat ? '0 : (opa >> sh_amt);
  assign sh_rari = sh_sat ? {W{a_neg}} : W'($signed(opa) >>> sh_amt);

  logic [W-1:0] prod;
  assign prod = opa * opb;

  assign div_zero = (op == OP_DIV) && (opb == '0);

  always_comb begin
    case (op)
      OP_PASS: result = opa;
      OP_ADD:  result = opa + opb;
      OP_SUB:  result = opa - opb;
      OP_MUL:  result = prod;
      OP_DIV:  result = div_zero ? '0 : floor_q;
      OP_ABS:  result = mag_a;
      OP_AND:  result = opa & opb;
      OP_OR:   result = opa | opb;
      OP_XOR:  result = opa ^ opb;
      OP_NOT:  result = ~opa;
      OP_ASH:  result = b_neg ? sh_rari : sh_left;
      OP_LSH:  result = b_neg ? sh_rlog : sh_left;
      default: result = '0;
    endcase
  end

  logic [W-1:0] chk_rem;
  assign chk_rem = opa - result * opb;

  always_comb begin
    if (div_zero)
      p_divz_zero_r3: assert (result == '0);
    if (op != OP_DIV)
      p_divz_only_div_r3: assert (!div_zero);
    if (op == OP_DIV && opb != '0)
      p_floor_rem_r2: assert (chk_rem == '0 || chk_rem[W-1] == b_neg);
    if (op == OP_ABS)
      p_abs_nonneg_r4: assert (!result[W-1] || opa == MOST_NEG);
    if (op > OP_LSH)
      p_unused_zero_r9: assert (result == '0);
    if ((op == OP_LSH || op == OP_ASH) && !b_neg && sh_sat)
      p_left_sat_r8: assert (result == '0);
    if (op == OP_ASH && b_neg)
      p_ash_sign_r6: assert (result[W-1] == a_neg);
  end
endmodule

// File: tb/sshift_alu_tb.sv
`timescale 1ns/1ps
module sshift_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = '0;
  logic [31:0] opa = '0, opb = '0;
  logic [31:0] result;
  logic        div_zero;
  int          n_chk = 0, n_bad = 0, cycles = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  sshift_alu u_dut (.op(op), .opa(opa), .opb(opb), .result(result), .div_zero(div_zero));

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] r;
    logic        dz;
  } vec_t;

  localparam int NV = 44;
  localparam vec_t VECS [NV] = '{
    {4'd1,  32'd5,        32'd7,        32'd12,       1'b0},
    {4'd1,  32'hFFFFFFFF, 32'd1,        32'd0,        1'b0},
    {4'd1,  32'd5,        32'd0,        32'd5,        1'b0},
    {4'd2,  32'd3,        32'd5,        32'hFFFFFFFE, 1'b0},
    {4'd3,  32'h00010000, 32'h00010000, 32'd0,        1'b0},
    {4'd3,  32'hFFFFFFFD, 32'd7,        32'hFFFFFFEB, 1'b0},
    {4'd4,  32'hFFFFFFF9, 32'd2,        32'hFFFFFFFC, 1'b0},
    {4'd4,  32'd7,        32'd2,        32'd3,        1'b0},
    {4'd4,  32'd7,        32'hFFFFFFFE, 32'hFFFFFFFC, 1'b0},
    {4'd4,  32'hFFFFFFF9, 32'hFFFFFFFE, 32'd3,        1'b0},
    {4'd4,  32'hFFFFFFF8, 32'd2,        32'hFFFFFFFC, 1'b0},
    {4'd4,  32'h80000000, 32'hFFFFFFFF, 32'h80000000, 1'b0},
    {4'd4,  32'd5,        32'd0,        32'd0,        1'b1},
    {4'd4,  32'h80000000, 32'd0,        32'd0,        1'b1},
    {4'd5,  32'hFFFFFFFB, 32'd0,        32'd5,        1'b0},
    {4'd5,  32'h80000000, 32'd0,        32'h80000000, 1'b0},
    {4'd5,  32'd9,        32'd0,        32'd9,        1'b0},
    {4'd6,  32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 1'b0},
    {4'd7,  32'hF0F0F0F0, 32'h0F000000, 32'hFFF0F0F0, 1'b0},
    {4'd8,  32'hFFFF0000, 32'h0F0F0F0F, 32'hF0F00F0F, 1'b0},
    {4'd9,  32'h12345678, 32'd0,        32'hEDCBA987, 1'b0},
    {4'd0,  32'hDEADBEEF, 32'd0,        32'hDEADBEEF, 1'b0},
    {4'd10, 32'h80000010, 32'hFFFFFFFC, 32'hF8000001, 1'b0},
    {4'd10, 32'd1,        32'd31,       32'h80000000, 1'b0},
    {4'd10, 32'h00001234, 32'd0,        32'h00001234, 1'b0},
    {4'd10, 32'h40000010, 32'hFFFFFFFC, 32'h04000001, 1'b0},
    {4'd10, 32'd1,        32'd32,       32'd0,        1'b0},
    {4'd10, 32'h80000000, 32'hFFFFFFD8, 32'hFFFFFFFF, 1'b0},
    {4'd10, 32'h40000000, 32'hFFFFFFD8, 32'd0,        1'b0},
    {4'd10, 32'h80000000, 32'h80000000, 32'hFFFFFFFF, 1'b0},
    {4'd10, 32'h80000000, 32'hFFFFFFE0, 32'hFFFFFFFF, 1'b0},
    {4'd10, 32'h80000000, 32'hFFFFFFE1, 32'hFFFFFFFF, 1'b0},
    {4'd11, 32'h80000010, 32'hFFFFFFFC, 32'h08000001, 1'b0},
    {4'd11, 32'd3,        32'd4,        32'h00000030, 1'b0},
    {4'd11, 32'hFFFFFFFF, 32'hFFFFFFE1, 32'h00000001, 1'b0},
    {4'd11, 32'hFFFFFFFF, 32'hFFFFFFE0, 32'd0,        1'b0},
    {4'd11, 32'hFFFFFFFF, 32'd33,       32'd0,        1'b0},
    {4'd11, 32'hFFFFFFFF, 32'h80000000, 32'd0,        1'b0},
    {4'd12, 32'd5,        32'd7,        32'd0,        1'b0},
    {4'd13, 32'hFFFFFFFF, 32'd0,        32'd0,        1'b0},
    {4'd14, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'd0,        1'b0},
    {4'd15, 32'd9,        32'd0,        32'd0,        1'b0},
    {4'd6,  32'd5,        32'd0,        32'd0,        1'b0},
    {4'd9,  32'd0,        32'd0,        32'hFFFFFFFF, 1'b0}
  };

  function automatic string req_of(input logic [3:0] c, input logic dz, input logic [31:0] b);
    case (c)
      4'd1, 4'd2, 4'd3: return "R1";
      4'd4:  return dz ? "R3" : ((b == 32'hFFFFFFFF) ? "R10/R2" : "R2");
      4'd5:  return "R4";
      4'd0, 4'd6, 4'd7, 4'd8, 4'd9: return "R5";
      4'd10: return (b[31] ? (-b) : b) >= 32 ? "R8" : "R6";
      4'd11: return (b[31] ? (-b) : b) >= 32 ? "R8" : "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] er, input logic edz);
    n_chk++;
    if (result !== er || div_zero !== edz) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%h b=%h: got result=%h div_zero=%b, expected result=%h div_zero=%b",
               tag, op, opa, opb, result, div_zero, er, edz);
    end
  endtask

  task automatic apply(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b);
    @(posedge clk);
    op = c; opa = a; opb = b;
    @(negedge clk);
  endtask

  function automatic logic [31:0] floor_div(input int a, input int b);
    int q;
    q = a / b;
    if ((a % b) != 0 && ((a < 0) != (b < 0))) q = q - 1;
    return 32'(q);
  endfunction

  function automatic logic [31:0] ref_shift(input logic [31:0] a, input int amt, input bit arith);
    longint v;
    if (amt >= 0) return (amt >= 32) ? 32'd0 : (a << amt);
    if (-amt >= 32) return arith ? {32{a[31]}} : 32'd0;
    if (arith) begin
      v = longint'($signed(a));
      return 32'(v / (longint'(1) << -amt) - ((v < 0 && (v % (longint'(1) << -amt)) != 0) ? 1 : 0));
    end
    return a >> -amt;
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R5 reset-state pass of zero", 32'd0, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].op, VECS[i].a, VECS[i].b);
      check(req_of(VECS[i].op, VECS[i].dz, VECS[i].b), VECS[i].r, VECS[i].dz);
    end

    // R2 floor quotient sweep against bench integer arithmetic
    for (int a = -9; a <= 9; a++) begin
      for (int k = 0; k < 4; k++) begin
        int b;
        b = (k == 0) ? -3 : (k == 1) ? -2 : (k == 2) ? 2 : 3;
        apply(4'd4, 32'(a), 32'(b));
        check("R2 sweep", floor_div(a, b), 1'b0);
      end
    end

    // R6 R7 R8 shift sweep across both directions and the saturation edge
    for (int s = -34; s <= 34; s++) begin
      apply(4'd11, 32'hC0000301, 32'(s));
      check((s >= 32 || s <= -32) ? "R8 lsh" : "R7 sweep", ref_shift(32'hC0000301, s, 1'b0), 1'b0);
      apply(4'd10, 32'hC0000301, 32'(s));
      check((s >= 32 || s <= -32) ? "R8 ash" : "R6 sweep", ref_shift(32'hC0000301, s, 1'b1), 1'b0);
    end

    // R3 div_zero stays low when opb is zero for non-divide codes
    for (int c = 0; c < 16; c++) begin
      if (c == 4) continue;
      apply(4'(c), 32'h12345678, 32'd0);
      n_chk++;
      if (div_zero !== 1'b0) begin
        n_bad++;
        $display("FAIL R3 op=%0d: got div_zero=%b, expected div_zero=0", c, div_zero);
      end
    end

    // R3 then R10: zero divisor followed by overflow case, no carry-over
    apply(4'd4, 32'h80000000, 32'd0);
    check("R3 back-to-back", 32'd0, 1'b1);
    apply(4'd4, 32'h80000000, 32'hFFFFFFFF);
    check("R10 back-to-back", 32'h80000000, 1'b0);

    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule